// File: doc/BRIEF.md
# Bit-Serial CRC-32 Generator

This block builds a 32-bit cyclic redundancy checksum from a stream of single data bits, taking one bit on each clock where the compute enable is high. A 32-bit linear feedback register holds the running remainder. Each step folds in exactly one data bit, and there is no whole-byte pre-mix. The raw register is brought out in parallel after every step, so a bit-level reference can follow it one step at a time. Messages may be of any length, including lengths that are not whole bytes.

The finished checksum is the bitwise inverse of the register. It is available in parallel, and it can also be streamed out serially, most significant bit first, under a second enable. During that unload the register shifts left and fills with ones. After 32 shifts it is back at the all-ones starting value, ready for the next message. A synchronous init input restarts a message at any time.

Top module: `crc32_serial`

## Requirements
- R1: Reset and `init_i` both load the register (`crc_o`) with 0xFFFFFFFF on the next clock edge.
- R2: A compute step forms feedback = `crc_o[31]` XOR `data_i`. It shifts the register left by one with a 0 entering bit 0, then XORs the generator polynomial 0x04C11DB7 into it when the feedback is 1.
- R3: Each clock with `calc_en_i` high, and with neither `init_i` nor `shift_en_i` high, consumes exactly one bit. With no enable high, the register holds its value.
- R4: Streams of any bit count are accepted, including counts that are not a multiple of 8. The register after every single bit equals the bit-by-bit result.
- R5: `checksum_o` is always the bitwise inverse of `crc_o`.
- R6: When `init_i` and `calc_en_i` are high in the same cycle, init wins. The register becomes 0xFFFFFFFF and that cycle's data bit is discarded.
- R7: While `shift_en_i` is high, `calc_en_i` is ignored. `serial_o` presents the inverted register MSB first: before the k-th shift it shows bit 31-k of the checksum taken when the unload began. Each shift moves the register left by one with a 1 entering bit 0.
- R8: After 32 shift enables the register reads 0xFFFFFFFF again.
- R9: The 32-bit word 0xABCD1234, fed least significant bit first after init, yields `checksum_o` = 0xE928FF7E.
- R10: All-zero messages of 8 bits and of 16 bits give different checksums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Restart: load the all-ones start value |
| calc_en_i | input | 1 | Consume `data_i` as the next message bit |
| data_i | input | 1 | Message bit |
| shift_en_i | input | 1 | Shift the checksum out by one bit |
| serial_o | output | 1 | Current serial checksum bit |
| crc_o | output | 32 | Raw feedback register |
| checksum_o | output | 32 | Inverted register (final checksum) |

## Verification
The hardest situation to reach is an enable collision: init together with a compute bit in the middle of a message, and compute held high with data 1 during every cycle of the unload. A wrong priority shows up only as a slightly altered register. The bench drives these collisions on purpose. It compares the register after each one with a reflected-form model, and it checks every serial bit against the checksum captured before the unload. Streams of 13 bits and of all zeros exercise the non-byte lengths.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;
    localparam int          CRC_W_DEF = 32;
    localparam logic [31:0] POLY_DEF  = 32'h04C1_1DB7;
    localparam logic [31:0] SEED_DEF  = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SEED  = 2'd1,
        OP_UNLD  = 2'd2,
        OP_FOLD  = 2'd3
    } crc_op_e;

    typedef struct packed {
        crc_op_e op;
        logic    bit_in;
    } crc_cmd_t;

    // Priority: seed over unload over fold.
    function automatic crc_op_e pick_op(logic seed, logic unld, logic fold);
        if (seed)      return OP_SEED;
        else if (unld) return OP_UNLD;
        else if (fold) return OP_FOLD;
        else           return OP_HOLD;
    endfunction
endpackage

// File: rtl/crc_cmd_decode.sv
module crc_cmd_decode
    import crc_serial_pkg::*;
(
    input  logic     init_i,
    input  logic     calc_en_i,
    input  logic     data_i,
    input  logic     shift_en_i,
    output crc_cmd_t cmd_o
);
    always_comb begin
        cmd_o.op     = pick_op(init_i, shift_en_i, calc_en_i);
        cmd_o.bit_in = data_i;
    end
endmodule

// File: rtl/crc_lfsr_core.sv
module crc_lfsr_core
    import crc_serial_pkg::*;
#(
    parameter int               W    = CRC_W_DEF,
    parameter logic [W-1:0]     POLY = POLY_DEF[W-1:0],
    parameter logic [W-1:0]     SEED = SEED_DEF[W-1:0]
) (
    input  logic         clk,
    input  logic         rst,
    input  crc_cmd_t     cmd_i,
    output logic [W-1:0] state_o
);
    localparam int TOP = W - 1;

    logic [W-1:0] state_q;
    logic [W-1:0] fold_next;
    logic         feedback;

    always_comb begin
        feedback  = state_q[TOP] ^ cmd_i.bit_in;
        fold_next = {state_q[TOP-1:0], 1'b0} ^ (feedback ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else begin
            unique case (cmd_i.op)
                OP_SEED: state_q <= SEED;
                OP_UNLD: state_q <= {state_q[TOP-1:0], 1'b1};
                OP_FOLD: state_q <= fold_next;
                default: state_q <= state_q;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/crc_out_tap.sv
module crc_out_tap #(
    parameter int W = 32
) (
    input  logic [W-1:0] state_i,
    output logic [W-1:0] checksum_o,
    output logic         serial_o
);
    always_comb begin
        checksum_o = ~state_i;
        serial_o   = checksum_o[W-1];
    end
endmodule

// File: rtl/crc32_serial.sv
module crc32_serial
    import crc_serial_pkg::*;
#(
    parameter int               W    = CRC_W_DEF,
    parameter logic [W-1:0]     POLY = POLY_DEF[W-1:0],
    parameter logic [W-1:0]     SEED = SEED_DEF[W-1:0]
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init_i,
    input  logic         calc_en_i,
    input  logic         data_i,
    input  logic         shift_en_i,
    output logic         serial_o,
    output logic [W-1:0] crc_o,
    output logic [W-1:0] checksum_o
);
    crc_cmd_t cmd;

    crc_cmd_decode u_dec (
        .init_i     (init_i),
        .calc_en_i  (calc_en_i),
        .data_i     (data_i),
        .shift_en_i (shift_en_i),
        .cmd_o      (cmd)
    );

    crc_lfsr_core #(.W(W), .POLY(POLY), .SEED(SEED)) u_core (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .state_o (crc_o)
    );

    crc_out_tap #(.W(W)) u_tap (
        .state_i    (crc_o),
        .checksum_o (checksum_o),
        .serial_o   (serial_o)
    );
endmodule

// File: rtl/crc32_serial_chk.sv
module crc32_serial_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         init_i,
    input logic         calc_en_i,
    input logic         data_i,
    input logic         shift_en_i,
    input logic         serial_o,
    input logic [W-1:0] crc_o,
    input logic [W-1:0] checksum_o
);
    // R1: reset seeds all ones
    p_reset_seed_r1: assert property (@(posedge clk)
        rst |=> crc_o == {W{1'b1}});

    // R1 / R6: init wins over everything
    p_init_seed_r6: assert property (@(posedge clk) disable iff (rst)
        init_i |=> crc_o == {W{1'b1}});

    // R3: idle cycles hold the register
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!init_i && !calc_en_i && !shift_en_i) |=> $stable(crc_o));

    // R2: bit 0 after a fold equals the feedback term (polynomial bit 0 is 1)
    p_fold_lsb_r2: assert property (@(posedge clk) disable iff (rst)
        (calc_en_i && !init_i && !shift_en_i)
        |=> crc_o[0] == ($past(crc_o[W-1]) ^ $past(data_i)));

    // R7: unload shifts left with a 1 entering, regardless of calc_en_i
    p_unload_shift_r7: assert property (@(posedge clk) disable iff (rst)
        (shift_en_i && !init_i)
        |=> (crc_o[0] == 1'b1) && (crc_o[W-1:1] == $past(crc_o[W-2:0])));

    // R7: the serial bit after a shift is the next checksum bit
    p_serial_next_r7: assert property (@(posedge clk) disable iff (rst)
        (shift_en_i && !init_i) |=> serial_o == $past(checksum_o[W-2]));

    // R5: inversion relation seen at the ports
    p_invert_r5: assert property (@(posedge clk) disable iff (rst)
        (checksum_o ^ crc_o) == {W{1'b1}});
endmodule

bind crc32_serial crc32_serial_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .init_i     (init_i),
    .calc_en_i  (calc_en_i),
    .data_i     (data_i),
    .shift_en_i (shift_en_i),
    .serial_o   (serial_o),
    .crc_o      (crc_o),
    .checksum_o (checksum_o)
);

// File: tb/crc32_serial_test.sv
module crc32_serial_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_i = 1'b0;
    logic        calc_en_i = 1'b0;
    logic        data_i = 1'b0;
    logic        shift_en_i = 1'b0;
    logic        serial_o;
    logic [31:0] crc_o;
    logic [31:0] checksum_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // Reflected-form reference: right-shifting register, mirrored polynomial.
    logic [31:0] ref_q = 32'hFFFF_FFFF;

    crc32_serial uut (
        .clk        (clk),
        .rst        (rst),
        .init_i     (init_i),
        .calc_en_i  (calc_en_i),
        .data_i     (data_i),
        .shift_en_i (shift_en_i),
        .serial_o   (serial_o),
        .crc_o      (crc_o),
        .checksum_o (checksum_o)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] mirror(logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic ref_bit(logic d);
        logic fb;
        fb = ref_q[0] ^ d;
        ref_q = (ref_q >> 1) ^ (fb ? 32'hEDB8_8320 : 32'h0);
    endtask

    // One compute step, register compared after it (R2, R3, R4).
    task automatic feed(logic d, string req);
        @(negedge clk);
        calc_en_i = 1'b1; data_i = d;
        @(negedge clk);
        calc_en_i = 1'b0;
        ref_bit(d);
        check(req, crc_o, mirror(ref_q));
    endtask

    task automatic restart();
        @(negedge clk);
        init_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0;
        ref_q = 32'hFFFF_FFFF;
        check("R1 init", crc_o, 32'hFFFF_FFFF);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] snap, z8, z16, word;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", crc_o, 32'hFFFF_FFFF);
        check("R5 reset", checksum_o, 32'h0);

        // R9: self vector, LSB first, every step compared
        word = 32'hABCD_1234;
        for (int i = 0; i < 32; i++) feed(word[i], "R2 R4 vector step");
        check("R9 vector checksum", checksum_o, 32'hE928_FF7E);
        check("R5 inversion", checksum_o, ~mirror(ref_q));

        // R3: idle cycles hold
        snap = crc_o;
        repeat (3) @(negedge clk);
        check("R3 hold", crc_o, snap);

        // R7: unload with calc_en_i and data_i held high; R8 refill
        snap = checksum_o;
        for (int k = 0; k < 32; k++) begin
            @(negedge clk);
            check("R7 serial bit", {31'b0, serial_o}, {31'b0, snap[31-k]});
            shift_en_i = 1'b1; calc_en_i = 1'b1; data_i = 1'b1;
            @(negedge clk);
            shift_en_i = 1'b0; calc_en_i = 1'b0; data_i = 1'b0;
        end
        check("R8 refilled", crc_o, 32'hFFFF_FFFF);

        // R4: 13-bit stream, not a byte multiple
        restart();
        for (int i = 0; i < 13; i++) feed(logic'((i * 5 + 1) % 3 == 0), "R4 odd length");

        // R6: init and calc together mid-stream, data 1 discarded
        @(negedge clk);
        init_i = 1'b1; calc_en_i = 1'b1; data_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0; calc_en_i = 1'b0; data_i = 1'b0;
        ref_q = 32'hFFFF_FFFF;
        check("R6 init priority", crc_o, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) feed(logic'(i[0]), "R6 after collision");

        // R10: zero messages of different lengths
        restart();
        for (int i = 0; i < 8; i++) feed(1'b0, "R4 zero8");
        z8 = checksum_o;
        restart();
        for (int i = 0; i < 16; i++) feed(1'b0, "R4 zero16");
        z16 = checksum_o;
        check("R10 zero lengths differ", {31'b0, z8 != z16}, 32'h1);

        // Reset mid-stream
        feed(1'b1, "R2 pre-reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-stream", crc_o, 32'hFFFF_FFFF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule